// File: doc/BRIEF.md
# MDIO Station Management Master

This block is the station side of a two-wire management bus. It divides the system clock down to a free-running management clock and shifts whole management frames out on the shared data line. A single command carries the frame style (direct or indirect), the opcode, the port address, the device or register address, a 16-bit address for indirect access, and write data. For indirect reads and writes the block issues two frames on its own: first an address frame, then the data frame.

Each frame has 64 bit times. It starts with a preamble of ones and then carries the start code, opcode, port, device/register, turnaround and 16-bit data fields, each sent most significant bit first. On read frames the station releases the line for turnaround and data and samples the device's reply. The block raises `busy` while a command is in progress. When the last frame has finished it pulses `done`, and for reads it presents the returned word on `rd_data`. Pad drivers and the meaning of device registers are left to the surrounding logic.

Top module: `mdio_master`

## Requirements
- R1: `mdc` toggles continuously after reset. It stays high for exactly MDC_HALF system clock cycles and low for exactly MDC_HALF cycles.
- R2: Every frame is 64 bit times with the line driven. The frame sends 32 ones, then start code (2 bits), opcode (2), port (5), device/register (5), turnaround (2) and data (16), each field MSB first. The device samples each bit on the rising edge of `mdc`.
- R3: With `cmd_indirect`=0 the block sends exactly one frame. Its start code is 01, its opcode is `cmd_op` (01 write, 10 read; only 10 is treated as a read), its port is `cmd_port` and its register field is `cmd_dev`.
- R4: With `cmd_indirect`=1 and `cmd_op` of 01 (write) or 11 (read), the block sends two frames. The first is an address frame with start code 00, opcode 00 and data equal to `cmd_addr`. The second uses start code 00, opcode `cmd_op`, and the same port and device.
- R5: With `cmd_indirect`=1 and `cmd_op` of 10 (read with post-increment) or 00 (address only), the block sends exactly one frame with start code 00. The address-only frame carries `cmd_addr` as its data.
- R6: On every frame the station drives (writes and address frames), the turnaround is sent as 1 then 0. The data field is `cmd_wdata` for writes.
- R7: On read frames `mdio_oe` is low for both turnaround bits and all 16 data bits. Data is sampled on rising `mdc`, MSB first. The result appears on `rd_data` in the cycle `done` is high. Commands without a read leave `rd_data` unchanged.
- R8: `mdio_o` and `mdio_oe` change only in the system cycle in which `mdc` falls.
- R9: A command is accepted when `cmd_valid` is high while `busy` is low. `busy` is high from the next cycle until the last frame ends. `done` is a one-cycle pulse with `busy` low. A `cmd_valid` seen while `busy` is high has no effect on the frames sent.
- R10: During reset `mdc` is 0, `mdio_oe` is 0, `busy` and `done` are 0, and `rd_data` is 0.
- R11: `mdio_oe` is low whenever `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_indirect | input | 1 | 1: indirect frames (start 00), 0: direct (start 01) |
| cmd_op | input | 2 | Opcode |
| cmd_port | input | 5 | Port address |
| cmd_dev | input | 5 | Device (indirect) or register (direct) address |
| cmd_addr | input | 16 | Register address for indirect access |
| cmd_wdata | input | 16 | Write data |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Last read result |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input |

## Verification
The bench builds the block with MDC_HALF=3, which gives a six-cycle management clock, and keeps the default 32-bit preamble. With these values each two-frame indirect access takes under a thousand cycles. That leaves room for dozens of random commands plus directed cases in one run: an address pointer wrapping from FFFF to 0000 under post-increment reads, all-ones port and register fields, and a command poked in while busy. The odd half period also checks that the divider counts exactly, not just by powers of two.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int PA_W   = 5;
  localparam int DA_W   = 5;
  localparam int DATA_W = 16;
  localparam int HDR_W  = 32;

  localparam logic [1:0] ST_DIRECT   = 2'b01;
  localparam logic [1:0] ST_INDIRECT = 2'b00;
  localparam logic [1:0] OP_ADDRESS  = 2'b00;
  localparam logic [1:0] OP_WRITE    = 2'b01;
  localparam logic [1:0] OP_DIR_RD   = 2'b10;
  localparam logic [1:0] OP_RD_INC   = 2'b10;
  localparam logic [1:0] OP_IND_RD   = 2'b11;
  localparam logic [1:0] TA_DRIVEN   = 2'b10;

  typedef enum logic [1:0] {SQ_IDLE, SQ_ADDR, SQ_DATA} seq_state_t;
  typedef enum logic [1:0] {SH_IDLE, SH_ARM, SH_RUN}   shf_state_t;

  function automatic logic [HDR_W-1:0] mk_hdr(input logic [1:0] st,
                                              input logic [1:0] op,
                                              input logic [PA_W-1:0] pa,
                                              input logic [DA_W-1:0] da,
                                              input logic [DATA_W-1:0] d);
    return {st, op, pa, da, TA_DRIVEN, d};
  endfunction
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int MDC_HALF = 10
) (
  input  logic clk,
  input  logic rst_n,
  output logic mdc,
  output logic rise_stb,
  output logic fall_stb
);
  localparam int CW = (MDC_HALF > 1) ? $clog2(MDC_HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(MDC_HALF - 1);

  logic [CW-1:0] cnt_q, cnt_n;
  logic          mdc_q, mdc_n;
  logic          wrap;

  always_comb begin
    wrap     = (cnt_q == LAST);
    cnt_n    = wrap ? '0 : cnt_q + 1'b1;
    mdc_n    = wrap ? ~mdc_q : mdc_q;
    rise_stb = wrap & ~mdc_q;
    fall_stb = wrap &  mdc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      mdc_q <= mdc_n;
    end
  end

  assign mdc = mdc_q;

  generate
    if (MDC_HALF > 1) begin : g_hold_chk
      // R1: a level lasts longer than one system cycle
      a_r1_mdc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc_q != $past(mdc_q)) |=> $stable(mdc_q));
    end
  endgenerate
endmodule

// File: rtl/mdio_shifter.sv
module mdio_shifter
  import mdio_pkg::*;
#(
  parameter int PRE_LEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rise_stb,
  input  logic              fall_stb,
  input  logic              start,
  input  logic [HDR_W-1:0]  hdr,
  input  logic              hdr_rd,
  input  logic              mdio_i,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              frame_done,
  output logic [DATA_W-1:0] cap_data
);
  localparam int FRAME_W = PRE_LEN + HDR_W;
  localparam int CNT_W   = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_W - 1);
  localparam logic [CNT_W-1:0] TA_IDX   = CNT_W'(PRE_LEN + 14);
  localparam logic [CNT_W-1:0] DAT_IDX  = CNT_W'(PRE_LEN + 16);

  shf_state_t          st_q, st_n;
  logic [FRAME_W-1:0]  sr_q, sr_n;
  logic [CNT_W-1:0]    bcnt_q, bcnt_n, bnext;
  logic                rd_q, rd_n;
  logic                o_q, o_n, oe_q, oe_n;
  logic                fd_q, fd_n;
  logic [DATA_W-1:0]   cap_q, cap_n;

  always_comb begin
    st_n   = st_q;
    sr_n   = sr_q;
    bcnt_n = bcnt_q;
    rd_n   = rd_q;
    o_n    = o_q;
    oe_n   = oe_q;
    fd_n   = 1'b0;
    cap_n  = cap_q;
    bnext  = bcnt_q + 1'b1;
    case (st_q)
      SH_IDLE: begin
        if (start) begin
          sr_n = {{PRE_LEN{1'b1}}, hdr};
          rd_n = hdr_rd;
          st_n = SH_ARM;
        end
      end
      SH_ARM: begin
        if (fall_stb) begin
          o_n    = sr_q[FRAME_W-1];
          oe_n   = 1'b1;
          bcnt_n = '0;
          st_n   = SH_RUN;
        end
      end
      SH_RUN: begin
        if (rise_stb && rd_q && (bcnt_q >= DAT_IDX))
          cap_n = {cap_q[DATA_W-2:0], mdio_i};
        if (fall_stb) begin
          if (bcnt_q == LAST_IDX) begin
            st_n = SH_IDLE;
            o_n  = 1'b1;
            oe_n = 1'b0;
            fd_n = 1'b1;
          end else begin
            bcnt_n = bnext;
            sr_n   = {sr_q[FRAME_W-2:0], 1'b0};
            o_n    = sr_q[FRAME_W-2];
            oe_n   = !(rd_q && (bnext >= TA_IDX));
          end
        end
      end
      default: st_n = SH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SH_IDLE;
      sr_q   <= '0;
      bcnt_q <= '0;
      rd_q   <= 1'b0;
      o_q    <= 1'b1;
      oe_q   <= 1'b0;
      fd_q   <= 1'b0;
      cap_q  <= '0;
    end else begin
      st_q   <= st_n;
      sr_q   <= sr_n;
      bcnt_q <= bcnt_n;
      rd_q   <= rd_n;
      o_q    <= o_n;
      oe_q   <= oe_n;
      fd_q   <= fd_n;
      cap_q  <= cap_n;
    end
  end

  assign mdio_o     = o_q;
  assign mdio_oe    = oe_q;
  assign frame_done = fd_q;
  assign cap_data   = cap_q;

  // R7: line released through turnaround and data of a read frame
  a_r7_read_release: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SH_RUN && rd_q && bcnt_q >= TA_IDX) |-> !oe_q);
  // R2: a new frame is only handed over to an idle shifter
  a_r2_start_idle: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (st_q == SH_IDLE));
  // R2: the whole preamble and header are driven on a write-type frame
  a_r2_driven_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SH_RUN && !rd_q) |-> oe_q);
endmodule

// File: rtl/mdio_seq.sv
module mdio_seq
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_indirect,
  input  logic [1:0]        cmd_op,
  input  logic [PA_W-1:0]   cmd_port,
  input  logic [DA_W-1:0]   cmd_dev,
  input  logic [DATA_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  input  logic              frame_done,
  input  logic [DATA_W-1:0] cap_data,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic              start,
  output logic [HDR_W-1:0]  hdr,
  output logic              hdr_rd
);
  seq_state_t        st_q, st_n;
  logic [PA_W-1:0]   pa_q, pa_n;
  logic [DA_W-1:0]   da_q, da_n;
  logic [1:0]        op_q, op_n;
  logic [DATA_W-1:0] wd_q, wd_n;
  logic              start_q, start_n;
  logic [HDR_W-1:0]  hdr_q, hdr_n;
  logic              hrd_q, hrd_n;
  logic              done_q, done_n;
  logic [DATA_W-1:0] rdat_q, rdat_n;
  logic              two_frames, cmd_rd;
  logic [DATA_W-1:0] single_data;

  always_comb begin
    st_n    = st_q;
    pa_n    = pa_q;
    da_n    = da_q;
    op_n    = op_q;
    wd_n    = wd_q;
    start_n = 1'b0;
    hdr_n   = hdr_q;
    hrd_n   = hrd_q;
    done_n  = 1'b0;
    rdat_n  = rdat_q;
    two_frames  = cmd_indirect && (cmd_op == OP_WRITE || cmd_op == OP_IND_RD);
    cmd_rd      = cmd_indirect ? cmd_op[1] : (cmd_op == OP_DIR_RD);
    single_data = (cmd_indirect && cmd_op == OP_ADDRESS) ? cmd_addr : cmd_wdata;
    case (st_q)
      SQ_IDLE: begin
        if (cmd_valid) begin
          pa_n    = cmd_port;
          da_n    = cmd_dev;
          op_n    = cmd_op;
          wd_n    = cmd_wdata;
          start_n = 1'b1;
          if (two_frames) begin
            hdr_n = mk_hdr(ST_INDIRECT, OP_ADDRESS, cmd_port, cmd_dev, cmd_addr);
            hrd_n = 1'b0;
            st_n  = SQ_ADDR;
          end else begin
            hdr_n = mk_hdr(cmd_indirect ? ST_INDIRECT : ST_DIRECT, cmd_op,
                           cmd_port, cmd_dev, single_data);
            hrd_n = cmd_rd;
            st_n  = SQ_DATA;
          end
        end
      end
      SQ_ADDR: begin
        if (frame_done) begin
          hdr_n   = mk_hdr(ST_INDIRECT, op_q, pa_q, da_q, wd_q);
          hrd_n   = (op_q == OP_IND_RD);
          start_n = 1'b1;
          st_n    = SQ_DATA;
        end
      end
      SQ_DATA: begin
        if (frame_done) begin
          st_n   = SQ_IDLE;
          done_n = 1'b1;
          if (hrd_q) rdat_n = cap_data;
        end
      end
      default: st_n = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= SQ_IDLE;
      pa_q    <= '0;
      da_q    <= '0;
      op_q    <= '0;
      wd_q    <= '0;
      start_q <= 1'b0;
      hdr_q   <= '0;
      hrd_q   <= 1'b0;
      done_q  <= 1'b0;
      rdat_q  <= '0;
    end else begin
      st_q    <= st_n;
      pa_q    <= pa_n;
      da_q    <= da_n;
      op_q    <= op_n;
      wd_q    <= wd_n;
      start_q <= start_n;
      hdr_q   <= hdr_n;
      hrd_q   <= hrd_n;
      done_q  <= done_n;
      rdat_q  <= rdat_n;
    end
  end

  assign busy    = (st_q != SQ_IDLE);
  assign done    = done_q;
  assign rd_data = rdat_q;
  assign start   = start_q;
  assign hdr     = hdr_q;
  assign hdr_rd  = hrd_q;

  // R9: completion is reported with the block already free
  a_r9_done_free: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R9: done lasts one cycle
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R9: busy only rises after a request
  a_r9_busy_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_valid));
  // R4: end of the address frame launches the data frame at once
  a_r4_chain: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SQ_ADDR && frame_done) |=> (start_q && st_q == SQ_DATA));
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int MDC_HALF = 10,
  parameter int PRE_LEN  = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  input  logic        cmd_indirect,
  input  logic [1:0]  cmd_op,
  input  logic [4:0]  cmd_port,
  input  logic [4:0]  cmd_dev,
  input  logic [15:0] cmd_addr,
  input  logic [15:0] cmd_wdata,
  output logic        busy,
  output logic        done,
  output logic [15:0] rd_data,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic [1:0]        rs_q;
  logic              rst_i_n;
  logic              rise_stb, fall_stb;
  logic              start, hdr_rd, frame_done;
  logic [HDR_W-1:0]  hdr;
  logic [DATA_W-1:0] cap_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  mdio_clkgen #(.MDC_HALF(MDC_HALF)) u_clk (
    .clk(clk), .rst_n(rst_i_n), .mdc(mdc),
    .rise_stb(rise_stb), .fall_stb(fall_stb));

  mdio_seq u_seq (
    .clk(clk), .rst_n(rst_i_n), .cmd_valid(cmd_valid),
    .cmd_indirect(cmd_indirect), .cmd_op(cmd_op), .cmd_port(cmd_port),
    .cmd_dev(cmd_dev), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .frame_done(frame_done), .cap_data(cap_data), .busy(busy), .done(done),
    .rd_data(rd_data), .start(start), .hdr(hdr), .hdr_rd(hdr_rd));

  mdio_shifter #(.PRE_LEN(PRE_LEN)) u_shf (
    .clk(clk), .rst_n(rst_i_n), .rise_stb(rise_stb), .fall_stb(fall_stb),
    .start(start), .hdr(hdr), .hdr_rd(hdr_rd), .mdio_i(mdio_i),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .frame_done(frame_done),
    .cap_data(cap_data));

  // R8: the data line moves only on a falling management clock
  a_r8_fall_only: assert property (@(posedge clk) disable iff (!rst_i_n)
    (mdio_o != $past(mdio_o) || mdio_oe != $past(mdio_oe)) |-> (!mdc && $past(mdc)));
  // R11: line released whenever no command is in progress
  a_r11_idle_release: assert property (@(posedge clk) disable iff (!rst_i_n)
    !busy |-> !mdio_oe);
endmodule

// File: tb/mdio_master_tb_top.sv
module mdio_master_tb_top;
  localparam int HALF = 3;
  localparam int WD_LIMIT = 190000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_indirect = 1'b0;
  logic [1:0]  cmd_op = 2'b00;
  logic [4:0]  cmd_port = '0;
  logic [4:0]  cmd_dev = '0;
  logic [15:0] cmd_addr = '0;
  logic [15:0] cmd_wdata = '0;
  logic        busy, done, mdc, mdio_o, mdio_oe;
  logic [15:0] rd_data;
  logic        mdio_i = 1'b1;

  mdio_master #(.MDC_HALF(HALF), .PRE_LEN(32)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_indirect(cmd_indirect),
    .cmd_op(cmd_op), .cmd_port(cmd_port), .cmd_dev(cmd_dev), .cmd_addr(cmd_addr),
    .cmd_wdata(cmd_wdata), .busy(busy), .done(done), .rd_data(rd_data),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i));

  always #10 clk = ~clk;

  int total = 0;
  int bad = 0;
  bit timeout = 1'b0;
  int cyc = 0;

  // device model state
  logic [15:0] mptr [0:1023];
  logic [15:0] eptr [0:1023];
  logic        pmdc = 1'b0, po = 1'b1, poe = 1'b0;
  int          edge_bad = 0, mdc_bad = 0, mdc_toggles = 0, runlen = 0;
  bit          in_fr = 1'b0, fr_rd = 1'b0;
  int          idx = 0;
  logic [63:0] fb, fe;
  logic [15:0] resp;
  int          nfr = 0;
  logic [1:0]  fr_st [0:3];
  logic [1:0]  fr_op [0:3];
  logic [4:0]  fr_pa [0:3];
  logic [4:0]  fr_da [0:3];
  logic [15:0] fr_d  [0:3];
  bit          fr_ok [0:3];

  function automatic logic [15:0] dir_val(input logic [4:0] pa, input logic [4:0] da);
    return {pa, da, 6'h2B} ^ 16'h5A3C;
  endfunction
  function automatic logic [15:0] ind_val(input logic [4:0] pa, input logic [4:0] da,
                                          input logic [15:0] a);
    return (a * 16'h9E37) ^ {pa, da, 6'h15};
  endfunction

  task automatic chk(input bit c, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!c) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // PHY model and line monitors, all sampled on the falling system clock
  always @(negedge clk) begin
    bit rd_now, pre_ok;
    cyc++;
    if (cyc > WD_LIMIT) timeout = 1'b1;
    if (!rst_n) begin
      mdio_i = 1'b1;
      in_fr  = 1'b0;
      runlen = 0;
    end else begin
      if ((mdio_o !== po || mdio_oe !== poe) && !(pmdc && !mdc)) edge_bad++;
      if (mdc !== pmdc) begin
        if (mdc_toggles > 0 && runlen != HALF) mdc_bad++;
        mdc_toggles++;
        runlen = 1;
      end else runlen++;
      if (mdc && !pmdc) begin
        if (!in_fr && mdio_oe) begin
          in_fr = 1'b1;
          idx   = 0;
        end
        if (in_fr) begin
          fb[63-idx] = mdio_o;
          fe[63-idx] = mdio_oe;
          idx++;
          if (idx == 46) begin
            rd_now = (fb[31:30] == 2'b01 && fb[29:28] == 2'b10) ||
                     (fb[31:30] == 2'b00 && fb[29]);
            fr_rd  = rd_now;
            if (fb[31:30] == 2'b01) resp = dir_val(fb[27:23], fb[22:18]);
            else resp = ind_val(fb[27:23], fb[22:18], mptr[{fb[27:23], fb[22:18]}]);
          end
          if (idx == 64) begin
            in_fr  = 1'b0;
            mdio_i = 1'b1;
            pre_ok = (fb[63:32] == '1) && (fe[63:32] == '1);
            if (nfr < 4) begin
              fr_st[nfr] = fb[31:30];
              fr_op[nfr] = fb[29:28];
              fr_pa[nfr] = fb[27:23];
              fr_da[nfr] = fb[22:18];
              fr_d[nfr]  = fb[15:0];
              fr_ok[nfr] = fr_rd ? (pre_ok && fe[31:18] == '1 && fe[17:0] == '0)
                                 : (pre_ok && fe[31:0] == '1 && fb[17:16] == 2'b10);
            end
            nfr++;
            if (fb[31:30] == 2'b00 && fb[29:28] == 2'b00)
              mptr[{fb[27:23], fb[22:18]}] = fb[15:0];
            if (fb[31:30] == 2'b00 && fb[29:28] == 2'b10)
              mptr[{fb[27:23], fb[22:18]}] = mptr[{fb[27:23], fb[22:18]}] + 16'd1;
          end
        end
      end else if (!mdc && pmdc) begin
        if (in_fr && fr_rd && idx >= 48 && idx <= 63) mdio_i = resp[63-idx];
      end
    end
    pmdc = mdc;
    po   = mdio_o;
    poe  = mdio_oe;
  end

  task automatic do_cmd(input bit ind, input logic [1:0] op, input logic [4:0] pa,
                        input logic [4:0] da, input logic [15:0] addr,
                        input logic [15:0] wd, input bit poke);
    int          nx;
    logic [1:0]  xst [0:1];
    logic [1:0]  xop [0:1];
    logic [15:0] xd  [0:1];
    bit          xrd [0:1];
    bit          isrd;
    logic [15:0] exp_rd, prev_rd;
    string       tag;
    isrd = ind ? op[1] : (op == 2'b10);
    prev_rd = rd_data;
    if (ind && (op == 2'b01 || op == 2'b11)) begin
      nx = 2; tag = "R4";
      xst[0] = 2'b00; xop[0] = 2'b00; xd[0] = addr; xrd[0] = 1'b0;
      xst[1] = 2'b00; xop[1] = op;    xd[1] = wd;   xrd[1] = isrd;
    end else begin
      nx = 1; tag = ind ? "R5" : "R3";
      xst[0] = ind ? 2'b00 : 2'b01; xop[0] = op;
      xd[0]  = (ind && op == 2'b00) ? addr : wd; xrd[0] = isrd;
      xst[1] = 2'b00; xop[1] = 2'b00; xd[1] = '0; xrd[1] = 1'b0;
    end
    exp_rd = prev_rd;
    if (!ind && op == 2'b10) exp_rd = dir_val(pa, da);
    if (ind && op == 2'b11) exp_rd = ind_val(pa, da, addr);
    if (ind && op == 2'b10) exp_rd = ind_val(pa, da, eptr[{pa, da}]);
    if (ind && op != 2'b10) eptr[{pa, da}] = addr;
    if (ind && op == 2'b10) eptr[{pa, da}] = eptr[{pa, da}] + 16'd1;

    nfr = 0;
    @(negedge clk);
    cmd_indirect = ind; cmd_op = op; cmd_port = pa; cmd_dev = da;
    cmd_addr = addr; cmd_wdata = wd; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(busy === 1'b1, "R9 busy after accept", {31'd0, busy}, 32'd1);
    if (poke) begin
      repeat (20) @(negedge clk);
      cmd_indirect = ~ind; cmd_op = ~op; cmd_port = ~pa; cmd_dev = ~da;
      cmd_addr = ~addr; cmd_wdata = ~wd; cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
    end
    while (done !== 1'b1 && !timeout) @(negedge clk);
    chk(busy === 1'b0, "R9 done with busy low", {31'd0, busy}, 32'd0);
    chk(mdio_oe === 1'b0, "R11 released when idle", {31'd0, mdio_oe}, 32'd0);
    chk(nfr == nx, {tag, " frame count"}, nfr, nx);
    for (int i = 0; i < 2; i++) begin
      if (i < nx && i < nfr) begin
        chk({fr_st[i], fr_op[i], fr_pa[i], fr_da[i]} == {xst[i], xop[i], pa, da},
            {tag, " header fields"}, {fr_st[i], fr_op[i], fr_pa[i], fr_da[i]},
            {xst[i], xop[i], pa, da});
        chk(fr_ok[i], xrd[i] ? "R7 read release" : "R2 R6 driven frame format",
            {31'd0, fr_ok[i]}, 32'd1);
        if (!xrd[i])
          chk(fr_d[i] == xd[i], "R6 data field", fr_d[i], xd[i]);
      end
    end
    chk(rd_data == exp_rd, "R7 read data", rd_data, exp_rd);
    @(negedge clk);
    chk(done === 1'b0, "R9 done single cycle", {31'd0, done}, 32'd0);
  endtask

  initial begin
    int seed;
    for (int i = 0; i < 1024; i++) begin
      mptr[i] = '0;
      eptr[i] = '0;
    end
    seed = $urandom(32'd1234);
    repeat (4) @(negedge clk);
    // R10: reset state
    chk(mdc === 1'b0, "R10 mdc", {31'd0, mdc}, 32'd0);
    chk(mdio_oe === 1'b0, "R10 oe", {31'd0, mdio_oe}, 32'd0);
    chk(busy === 1'b0 && done === 1'b0, "R10 busy done", {30'd0, busy, done}, 32'd0);
    chk(rd_data === 16'd0, "R10 rd_data", {16'd0, rd_data}, 32'd0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);

    // directed corners
    do_cmd(1'b0, 2'b01, 5'd31, 5'd31, 16'h0000, 16'hFFFF, 1'b0); // R3 write
    do_cmd(1'b0, 2'b10, 5'd0,  5'd0,  16'h0000, 16'h0000, 1'b0); // R3 read
    do_cmd(1'b1, 2'b01, 5'd3,  5'd1,  16'h1234, 16'hBEEF, 1'b0); // R4 write, R7 unchanged
    do_cmd(1'b1, 2'b11, 5'd3,  5'd1,  16'hFFFF, 16'h0000, 1'b0); // R4 read
    do_cmd(1'b1, 2'b00, 5'd7,  5'd2,  16'hFFFF, 16'h0000, 1'b0); // R5 address only
    do_cmd(1'b1, 2'b10, 5'd7,  5'd2,  16'h0000, 16'h0000, 1'b0); // R5 incr at FFFF
    do_cmd(1'b1, 2'b10, 5'd7,  5'd2,  16'h0000, 16'h0000, 1'b0); // R5 wrapped to 0000
    do_cmd(1'b1, 2'b11, 5'd9,  5'd4,  16'h00A5, 16'h0000, 1'b1); // R9 poke while busy

    for (int n = 0; n < 50 && !timeout; n++) begin
      bit          ind;
      logic [1:0]  op;
      ind = $urandom_range(0, 1) == 1;
      op  = ind ? 2'($urandom_range(0, 3)) : ($urandom_range(0, 1) == 1 ? 2'b10 : 2'b01);
      do_cmd(ind, op, 5'($urandom), 5'($urandom), 16'($urandom), 16'($urandom),
             $urandom_range(0, 7) == 0);
    end

    chk(mdc_toggles > 100 && mdc_bad == 0, "R1 mdc half period", mdc_bad, 0);
    chk(edge_bad == 0, "R8 change on falling mdc", edge_bad, 0);
    if (timeout) begin
      total++;
      bad++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, WD_LIMIT);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule